// File: doc/BRIEF.md
# Busy-Bank Toggle Status Generator

This block produces the status bit a flash-style memory returns while an internal program or erase is running. Each read of the busy bank during such an operation returns the opposite value from the previous read. When the device is idle, suspended, or reading a different bank, the bit holds its value. A companion select output tells the read path whether to drive this status or array data onto the data bus.

Command decoding upstream reports completed command sequences as single-cycle pulses: program, erase, suspend and resume. Each pulse comes with a protection qualifier. An external algorithm timer signals completion. Operations aimed at protected targets never reach that timer. Instead, the block runs its own timeout, keeps toggling for a parameterised number of cycles, and then falls back silently to array reads. Erase can be suspended, and a program can be nested inside the suspension.

Top module: `toggle_status`

## Requirements
- R1: After reset, status_bit is 0 and status_sel is 0.
- R2: While a program or erase is running and rd_busy_bank is 1, each rising edge of rd_stb inverts status_bit. The new value appears from the next clock. status_sel is 1 in that period.
- R3: status_bit changes only on a rising edge of rd_stb. Idle clocks and a strobe held high leave it unchanged.
- R4: With rd_busy_bank at 0, status_sel is 0 and a read strobe does not change status_bit.
- R5: A pulse on op_done ends a running unprotected program or erase. From the next clock status_sel is 0, and later reads leave status_bit unchanged.
- R6: Status is reported from the clock after an erase command is accepted, before the algorithm reports anything. This covers the erase time-out window.
- R7: An erase whose selected sectors are all protected (erase_all_prot=1) toggles for exactly ERASE_PROT_CYC cycles of status_sel, then returns to array reads without op_done.
- R8: A program to a protected target (prog_prot=1) toggles for exactly PROG_PROT_CYC cycles. It then returns to array reads, or to the erase-suspended condition if it was started inside a suspension.
- R9: cmd_suspend during an erase stops toggling: status_sel stays 1 and status_bit holds. cmd_resume restarts toggling.
- R10: A program started during erase suspend toggles again until op_done. The block then returns to the suspended, non-toggling condition with status_sel at 1.
- R11: An erase with erase_all_prot=0 (only some or no sectors protected) runs until op_done, however long that takes, even past ERASE_PROT_CYC.
- R12: Program and erase commands are ignored while an operation runs, and op_done is ignored while erase is suspended.
- R13: When cmd_prog and cmd_erase arrive in the same idle cycle, the program is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_prog | input | 1 | Program command sequence completed (one cycle) |
| cmd_erase | input | 1 | Erase command sequence completed (one cycle) |
| cmd_suspend | input | 1 | Erase suspend command (one cycle) |
| cmd_resume | input | 1 | Erase resume command (one cycle) |
| prog_prot | input | 1 | Program target is protected, valid with cmd_prog |
| erase_all_prot | input | 1 | Every selected erase sector is protected, valid with cmd_erase |
| op_done | input | 1 | Algorithm timer reports completion (one cycle) |
| rd_stb | input | 1 | Read strobe; a rising edge is one read |
| rd_busy_bank | input | 1 | Current read addresses the bank holding the operation |
| status_bit | output | 1 | Toggle status bit |
| status_sel | output | 1 | 1 selects status on the data bus, 0 selects array data |

## Verification
The bench uses short timeouts. It counts the exact number of cycles status_sel stays high after protected erase and protected program commands, so a timer that is off by one cycle or swaps the two lengths shows up as a wrong count. It drives reads during suspend, during a nested program, and after a nested program ends. A design that keeps toggling while suspended, or that falls back to idle instead of the suspension, fails the parity of the expected bit. It also sends stray erase and op_done pulses at moments when they must be ignored, and checks the outcome at status_sel.

// File: rtl/tgl_pkg.sv
package tgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_ERASE, ST_SUSP, ST_SPROG, ST_PPROT, ST_EPROT, ST_SPPROT
  } tgl_state_t;

  // states in which reads of the busy bank see a changing bit
  function automatic logic is_busy(tgl_state_t s);
    return s inside {ST_PROG, ST_ERASE, ST_SPROG, ST_PPROT, ST_EPROT, ST_SPPROT};
  endfunction

  // states in which status rather than array data is presented
  function automatic logic is_active(tgl_state_t s);
    return s != ST_IDLE;
  endfunction

  function automatic logic next_toggle(logic cur, logic rise, logic en);
    return cur ^ (rise & en);
  endfunction
endpackage

// File: rtl/tgl_timer.sv
module tgl_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= len - CW'(1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - CW'(1);
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/tgl_seq.sv
module tgl_seq
  import tgl_pkg::*;
#(
  parameter int          CW             = 8,
  parameter int unsigned ERASE_PROT_CYC = 6,
  parameter int unsigned PROG_PROT_CYC  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_prog,
  input  logic          cmd_erase,
  input  logic          cmd_suspend,
  input  logic          cmd_resume,
  input  logic          prog_prot,
  input  logic          erase_all_prot,
  input  logic          op_done,
  input  logic          tmo_done,
  output tgl_state_t    state,
  output logic          tmo_start,
  output logic [CW-1:0] tmo_len
);
  tgl_state_t nxt;

  always_comb begin
    nxt       = state;
    tmo_start = 1'b0;
    tmo_len   = '0;
    case (state)
      ST_IDLE: begin
        if (cmd_prog) begin
          if (prog_prot) begin
            nxt = ST_PPROT; tmo_start = 1'b1; tmo_len = CW'(PROG_PROT_CYC);
          end else nxt = ST_PROG;
        end else if (cmd_erase) begin
          if (erase_all_prot) begin
            nxt = ST_EPROT; tmo_start = 1'b1; tmo_len = CW'(ERASE_PROT_CYC);
          end else nxt = ST_ERASE;
        end
      end
      ST_PROG:  if (op_done) nxt = ST_IDLE;
      ST_ERASE: begin
        if (op_done)          nxt = ST_IDLE;
        else if (cmd_suspend) nxt = ST_SUSP;
      end
      ST_SUSP: begin
        if (cmd_resume) nxt = ST_ERASE;
        else if (cmd_prog) begin
          if (prog_prot) begin
            nxt = ST_SPPROT; tmo_start = 1'b1; tmo_len = CW'(PROG_PROT_CYC);
          end else nxt = ST_SPROG;
        end
      end
      ST_SPROG:  if (op_done)  nxt = ST_SUSP;
      ST_PPROT:  if (tmo_done) nxt = ST_IDLE;
      ST_EPROT:  if (tmo_done) nxt = ST_IDLE;
      ST_SPPROT: if (tmo_done) nxt = ST_SUSP;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/tgl_flip.sv
module tgl_flip
  import tgl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic flip_en,
  output logic rd_rise,
  output logic bit_q
);
  logic stb_q;

  assign rd_rise = rd_stb & ~stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      stb_q <= rd_stb;
      bit_q <= next_toggle(bit_q, rd_rise, flip_en);
    end
  end
endmodule

// File: rtl/toggle_status.sv
module toggle_status
  import tgl_pkg::*;
#(
  parameter int unsigned ERASE_PROT_CYC = 25000,
  parameter int unsigned PROG_PROT_CYC  = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_prog,
  input  logic cmd_erase,
  input  logic cmd_suspend,
  input  logic cmd_resume,
  input  logic prog_prot,
  input  logic erase_all_prot,
  input  logic op_done,
  input  logic rd_stb,
  input  logic rd_busy_bank,
  output logic status_bit,
  output logic status_sel
);
  localparam int unsigned MAX_LEN = (ERASE_PROT_CYC > PROG_PROT_CYC) ? ERASE_PROT_CYC : PROG_PROT_CYC;
  localparam int CW = $clog2(MAX_LEN + 1);

  tgl_state_t    state;
  logic          tmo_start, tmo_done;
  logic [CW-1:0] tmo_len;
  logic          busy, active, suspended, flip_en, rd_rise;

  tgl_seq #(.CW(CW), .ERASE_PROT_CYC(ERASE_PROT_CYC), .PROG_PROT_CYC(PROG_PROT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .prog_prot(prog_prot),
    .erase_all_prot(erase_all_prot), .op_done(op_done), .tmo_done(tmo_done),
    .state(state), .tmo_start(tmo_start), .tmo_len(tmo_len)
  );

  tgl_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmo_start), .len(tmo_len), .done(tmo_done)
  );

  assign busy      = is_busy(state);
  assign active    = is_active(state);
  assign suspended = (state == ST_SUSP);
  assign flip_en   = busy & rd_busy_bank;

  tgl_flip u_flip (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .flip_en(flip_en),
    .rd_rise(rd_rise), .bit_q(status_bit)
  );

  assign status_sel = active & rd_busy_bank;
endmodule

// File: rtl/tgl_chk.sv
module tgl_chk
  import tgl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_busy_bank,
  input logic       op_done,
  input logic       status_bit,
  input logic       status_sel,
  input logic       busy,
  input logic       suspended,
  input logic       rd_rise,
  input logic       tmo_done,
  input tgl_state_t state
);
  a_r2_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && busy && rd_busy_bank) |=> (status_bit != $past(status_bit)));

  a_r3_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(status_bit));

  a_r4_other_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_busy_bank |=> $stable(status_bit));

  a_r5_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && state == ST_PROG) |=> !status_sel);

  a_r9_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |=> $stable(status_bit));

  a_r8_timer_only_protected: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_done |-> (state inside {ST_PPROT, ST_EPROT, ST_SPPROT}));

  a_r12_suspend_ignores_done: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && op_done) |=> (state inside {ST_SUSP, ST_ERASE, ST_SPROG, ST_SPPROT}));
endmodule

bind toggle_status tgl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_busy_bank(rd_busy_bank), .op_done(op_done),
  .status_bit(status_bit), .status_sel(status_sel), .busy(busy),
  .suspended(suspended), .rd_rise(rd_rise), .tmo_done(tmo_done), .state(state)
);

// File: tb/toggle_status_test.sv
module toggle_status_test;
  localparam int EP = 6;
  localparam int PP = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_prog = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
  logic prog_prot = 0, erase_all_prot = 0, op_done = 0;
  logic rd_stb = 0, rd_busy_bank = 1;
  logic status_bit, status_sel;

  int errors = 0;
  int checks = 0;
  logic exp_bit = 1'b0;

  always #2 clk = ~clk;

  toggle_status #(.ERASE_PROT_CYC(EP), .PROG_PROT_CYC(PP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .prog_prot(prog_prot),
    .erase_all_prot(erase_all_prot), .op_done(op_done), .rd_stb(rd_stb),
    .rd_busy_bank(rd_busy_bank), .status_bit(status_bit), .status_sel(status_sel)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 prog, 1 erase, 2 suspend, 3 resume, 4 done
  task automatic pulse(int kind, logic prot);
    case (kind)
      0: begin cmd_prog = 1; prog_prot = prot; end
      1: begin cmd_erase = 1; erase_all_prot = prot; end
      2: cmd_suspend = 1;
      3: cmd_resume = 1;
      default: op_done = 1;
    endcase
    @(negedge clk);
    cmd_prog = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0;
    op_done = 0; prog_prot = 0; erase_all_prot = 0;
  endtask

  task automatic do_read(string req, logic bank, logic flips, logic sel_exp);
    rd_busy_bank = bank;
    rd_stb = 1;
    @(negedge clk);
    if (flips && bank) exp_bit = ~exp_bit;
    check(req, status_bit, exp_bit);
    check(req, status_sel, sel_exp);
    rd_stb = 0;
    @(negedge clk);
    rd_busy_bank = 1;
  endtask

  task automatic count_sel(output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      if (!status_sel) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 bit", status_bit, 1'b0);
    check("R1 sel", status_sel, 1'b0);
    rst_n = 1;
    @(negedge clk);
    do_read("R4 idle read", 1'b1, 1'b0, 1'b0);

    // R2 program toggles on every read of the busy bank
    pulse(0, 1'b0);
    check("R2 sel", status_sel, 1'b1);
    for (int i = 0; i < 6; i++) do_read("R2 read", 1'b1, 1'b1, 1'b1);

    // R3 strobe held high: single flip only
    rd_stb = 1;
    @(negedge clk);
    exp_bit = ~exp_bit;
    check("R3 first", status_bit, exp_bit);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3 held", status_bit, exp_bit);
    end
    rd_stb = 0;
    repeat (3) @(negedge clk);
    check("R3 idle", status_bit, exp_bit);

    // R4 other bank, alternating patterns
    for (int i = 0; i < 4; i++) do_read("R4 bank", (i % 2) == 1, 1'b1, (i % 2) == 1);

    // R12 erase ignored while programming, R5 done
    pulse(1, 1'b0);
    do_read("R12 busy read", 1'b1, 1'b1, 1'b1);
    pulse(4, 1'b0);
    check("R5 sel", status_sel, 1'b0);
    check("R12 erase ignored", status_sel, 1'b0);
    do_read("R5 after done", 1'b1, 1'b0, 1'b0);

    // R6 erase toggles at once, R9 suspend, R12 done ignored
    pulse(1, 1'b0);
    do_read("R6 timeout window", 1'b1, 1'b1, 1'b1);
    pulse(2, 1'b0);
    do_read("R9 suspended", 1'b1, 1'b0, 1'b1);
    pulse(4, 1'b0);
    check("R12 done in suspend", status_sel, 1'b1);
    do_read("R12 still suspended", 1'b1, 1'b0, 1'b1);
    // R10 nested program
    pulse(0, 1'b0);
    do_read("R10 nested", 1'b1, 1'b1, 1'b1);
    do_read("R10 nested", 1'b1, 1'b1, 1'b1);
    pulse(4, 1'b0);
    check("R10 back sel", status_sel, 1'b1);
    do_read("R10 back suspended", 1'b1, 1'b0, 1'b1);
    // R9 resume, R11 long erase
    pulse(3, 1'b0);
    do_read("R9 resumed", 1'b1, 1'b1, 1'b1);
    repeat (EP * 3) @(negedge clk);
    check("R11 still busy", status_sel, 1'b1);
    do_read("R11 late read", 1'b1, 1'b1, 1'b1);
    pulse(4, 1'b0);
    check("R11 done", status_sel, 1'b0);

    // R7 protected erase length
    pulse(1, 1'b1);
    count_sel(n);
    check_int("R7 length", n, EP);
    pulse(1, 1'b1);
    do_read("R7 toggles", 1'b1, 1'b1, 1'b1);
    repeat (EP) @(negedge clk);
    check("R7 released", status_sel, 1'b0);

    // R8 protected program length
    pulse(0, 1'b1);
    count_sel(n);
    check_int("R8 length", n, PP);
    do_read("R8 after", 1'b1, 1'b0, 1'b0);

    // R8 protected program inside suspend
    pulse(1, 1'b0);
    pulse(2, 1'b0);
    pulse(0, 1'b1);
    do_read("R8 nested toggles", 1'b1, 1'b1, 1'b1);
    repeat (PP) @(negedge clk);
    check("R8 nested sel", status_sel, 1'b1);
    do_read("R8 back suspended", 1'b1, 1'b0, 1'b1);
    pulse(3, 1'b0);
    pulse(4, 1'b0);
    check("R8 cleanup", status_sel, 1'b0);

    // R13 simultaneous program and erase: program wins (op_done ends it)
    cmd_prog = 1; cmd_erase = 1; erase_all_prot = 1;
    @(negedge clk);
    cmd_prog = 0; cmd_erase = 0; erase_all_prot = 0;
    repeat (EP + 2) @(negedge clk);
    check("R13 program chosen", status_sel, 1'b1);
    pulse(4, 1'b0);
    check("R13 done", status_sel, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule